// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Burst-Read Interface

This block turns single read and write requests from a small 16-bit processor into cycles on an external memory bus. It drives the address, the write data with its output enable, an address strobe, read and write strobes, and an I/O strobe. An 8-bit configuration register selects the interface. The basic interface spends two states on every access. The burst-read interface lets sequential reads that stay inside one aligned block complete in a shortened cycle with no new address strobe.

The processor presents a request and holds it until a single-cycle ready pulse appears in the last state of the bus cycle. Every accepted request passes through one dispatch state, so back-to-back accesses are separated by that state. When the optional turnaround is enabled, a write that follows a read in this way gets one extra quiet state before its cycle begins. The I/O strobe marks bus cycles whose address falls in one of four windows at the top of the address space.

Top module: `ext_bus_ctl`

## Requirements
- R1: After reset the configuration register reads 0xD3. Bit 7 and bit 0 are reserved. Bit 6 is turnaround enable (1). Bit 5 is burst mode (0). Bit 4 is burst length, where 1 gives 2 states. Bit 3 is block size, where 1 gives 8 words (0 at reset). Bits 2:1 are window select (01). All strobes are high and ready is low.
- R2: A write loads bits 6..1. Bits 7 and 0 always read 1, so writing 0x00 reads back 0x81 and writing 0xFF reads back 0xFF.
- R3: A basic cycle is accepted in the dispatch state and holds ready in its second state. The address is stable through the cycle. The address strobe is low, and the read strobe (reads) or the write strobe (writes) is low.
- R4: With bit 6 set, a write accepted right after the ready of a read, with no request-free dispatch state between them, takes one extra state before its cycle. With bit 6 clear it takes none. A dispatch state without a request cancels the pending turnaround.
- R5: In burst mode, a read at the address that follows the previous read, and inside its block, completes in 1 state (bit 4 = 0) or 2 states (bit 4 = 1) with the address strobe held high.
- R6: Bursts stop at aligned blocks of 4 words (bit 3 = 0) or 8 words (bit 3 = 1). The read that starts a new block takes a basic cycle.
- R7: A write, a non-sequential read, or any read with burst mode off ends the burst and uses a basic cycle.
- R8: The I/O strobe is low during a bus cycle when the top (2 + select) address bits are all ones, so code 0 covers a quarter of the space and each higher code halves the window.
- R9: Ready lasts one cycle. During a read's ready the returned data equals the bus input. During a write's ready the write data is driven with its enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Configuration register write enable |
| regWdata | input | 8 | Configuration write value |
| regRdata | output | 8 | Configuration readback |
| reqValid | input | 1 | Access request, held until ready |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address of the request |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| reqRdata | output | 16 | Read data returned to the processor |
| busAddr | output | 16 | External address |
| busDataOut | output | 16 | External write data |
| busDataOe | output | 1 | Write data output enable |
| busDataIn | input | 16 | External read data |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busAsN | output | 1 | Address strobe, active low |
| ioStrbN | output | 1 | I/O window strobe, active low |

## Verification
Counted from the falling edge where a request is presented, ready appears two edges later for a basic cycle, three for a cycle with turnaround, and one or two for a burst cycle. One more edge is added when the request follows the previous ready without a gap, for the dispatch state. The bench counts falling edges until ready and compares that count with a model of the turnaround flag and the burst position. Data, strobes and the I/O strobe are sampled at that same falling edge. Configuration readback is sampled one falling edge after the write.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

  // Position of each configuration field in the 8-bit register
  localparam int BIT_RSV_HI  = 7;
  localparam int BIT_TURN    = 6;
  localparam int BIT_BURST   = 5;
  localparam int BIT_LONG    = 4;
  localparam int BIT_EIGHT   = 3;
  localparam int BIT_SEL_HI  = 2;
  localparam int BIT_SEL_LO  = 1;
  localparam int BIT_RSV_LO  = 0;
  localparam logic [7:0] CFG_RESET = 8'hD3;

  typedef struct packed {
    logic       turnEn;
    logic       burstMode;
    logic       burstLong;
    logic       burstEight;
    logic [1:0] winSel;
  } cfg_t;

  // Strobes sent from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic cycOn;
    logic rdOn;
    logic wrOn;
    logic asOn;
    logic done;
    logic curWr;
  } strb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_TURN, S_T1, S_T2, S_B1, S_B2
  } bus_state_e;

endpackage

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  reqWrite,
  input  logic  seqHit,
  input  cfg_t  cfg,
  output strb_t strb,
  output logic  reqReady
);

  bus_state_e state, stateNext;
  logic curWrite;
  logic lastRead;
  logic finalState;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (reqWrite && lastRead && cfg.turnEn) stateNext = S_TURN;
          else if (!reqWrite && seqHit)           stateNext = S_B1;
          else                                    stateNext = S_T1;
        end
      end
      S_TURN:  stateNext = S_T1;
      S_T1:    stateNext = S_T2;
      S_T2:    stateNext = S_IDLE;
      S_B1:    stateNext = cfg.burstLong ? S_B2 : S_IDLE;
      S_B2:    stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign finalState = (state == S_T2) || (state == S_B2) ||
                      ((state == S_B1) && !cfg.burstLong);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      curWrite <= 1'b0;
      lastRead <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && reqValid) curWrite <= reqWrite;
      if (finalState)                  lastRead <= !curWrite;
      else if (state == S_IDLE && !reqValid) lastRead <= 1'b0;
    end
  end

  always_comb begin
    strb.capture = (state == S_IDLE) && reqValid;
    strb.cycOn   = (state == S_T1) || (state == S_T2) ||
                   (state == S_B1) || (state == S_B2);
    strb.rdOn    = strb.cycOn && !curWrite;
    strb.wrOn    = ((state == S_T1) || (state == S_T2)) && curWrite;
    strb.asOn    = (state == S_T1) || (state == S_T2);
    strb.done    = finalState;
    strb.curWr   = curWrite;
  end

  assign reqReady = finalState;

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  p_turn_then_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN) |=> (state == S_T1) && curWrite);

  p_burst_reads_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_B1) || (state == S_B2)) |-> !curWrite);

endmodule

// File: rtl/ext_bus_dp.sv
module ext_bus_dp
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqWrite,
  input  logic [DW-1:0] reqWdata,
  output logic [DW-1:0] reqRdata,
  input  strb_t         strb,
  output cfg_t          cfg,
  output logic          seqHit,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe,
  input  logic [DW-1:0] busDataIn,
  output logic          busRdN,
  output logic          busWrN,
  output logic          busAsN,
  output logic          ioStrbN
);

  localparam int MIN_TOP = 2;

  cfg_t          cfgQ;
  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdataQ;
  logic [AW-1:0] nextQ;
  logic          liveQ;
  logic [AW-1:0] addrInc;
  logic          sameBlock;
  logic [AW-1:0] winMask;
  logic          inWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ.turnEn     <= CFG_RESET[BIT_TURN];
      cfgQ.burstMode  <= CFG_RESET[BIT_BURST];
      cfgQ.burstLong  <= CFG_RESET[BIT_LONG];
      cfgQ.burstEight <= CFG_RESET[BIT_EIGHT];
      cfgQ.winSel     <= CFG_RESET[BIT_SEL_HI:BIT_SEL_LO];
    end else if (regWe) begin
      cfgQ.turnEn     <= regWdata[BIT_TURN];
      cfgQ.burstMode  <= regWdata[BIT_BURST];
      cfgQ.burstLong  <= regWdata[BIT_LONG];
      cfgQ.burstEight <= regWdata[BIT_EIGHT];
      cfgQ.winSel     <= regWdata[BIT_SEL_HI:BIT_SEL_LO];
    end
  end

  assign regRdata = {1'b1, cfgQ.turnEn, cfgQ.burstMode, cfgQ.burstLong,
                     cfgQ.burstEight, cfgQ.winSel, 1'b1};
  assign cfg = cfgQ;

  // Burst tracking: next sequential address and whether it stays in block
  assign addrInc   = addrQ + AW'(1);
  assign sameBlock = cfgQ.burstEight ? (|addrInc[2:0]) : (|addrInc[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      nextQ  <= '0;
      liveQ  <= 1'b0;
    end else begin
      if (strb.capture) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.done) begin
        nextQ <= addrInc;
        liveQ <= !strb.curWr && cfgQ.burstMode && sameBlock;
      end
    end
  end

  assign seqHit = liveQ && cfgQ.burstMode && !reqWrite && (reqAddr == nextQ);

  // I/O window: top (2 + select) address bits all ones
  always_comb begin
    winMask = '0;
    for (int i = 0; i < AW; i++) begin
      if (i >= AW - MIN_TOP - int'(cfgQ.winSel)) winMask[i] = 1'b1;
    end
    inWin = &(addrQ | ~winMask);
  end

  assign busAddr    = addrQ;
  assign busDataOut = wdataQ;
  assign busDataOe  = strb.wrOn;
  assign busRdN     = !strb.rdOn;
  assign busWrN     = !strb.wrOn;
  assign busAsN     = !strb.asOn;
  assign ioStrbN    = !(strb.cycOn && inWin);
  assign reqRdata   = busDataIn;

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cycOn && $past(strb.cycOn)) |-> $stable(busAddr));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWe) |-> $stable(regRdata));

  p_strobe_in_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ioStrbN |-> (!busRdN || !busWrN));

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busDataOe);

endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl
  import ext_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          reqReady,
  output logic [DW-1:0] reqRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busDataOut,
  output logic          busDataOe,
  input  logic [DW-1:0] busDataIn,
  output logic          busRdN,
  output logic          busWrN,
  output logic          busAsN,
  output logic          ioStrbN
);

  strb_t strb;
  cfg_t  cfg;
  logic  seqHit;

  ext_bus_seq uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .seqHit   (seqHit),
    .cfg      (cfg),
    .strb     (strb),
    .reqReady (reqReady)
  );

  ext_bus_dp #(.AW(AW), .DW(DW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .reqRdata   (reqRdata),
    .strb       (strb),
    .cfg        (cfg),
    .seqHit     (seqHit),
    .busAddr    (busAddr),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .busDataIn  (busDataIn),
    .busRdN     (busRdN),
    .busWrN     (busWrN),
    .busAsN     (busAsN),
    .ioStrbN    (ioStrbN)
  );

endmodule

// File: tb/ext_bus_ctl_test.sv
`timescale 1ns/1ps
module ext_bus_ctl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady;
  logic [15:0] reqRdata;
  logic [15:0] busAddr;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn;
  logic        busRdN, busWrN, busAsN, ioStrbN;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model of the configuration and the sequencing history
  bit mTurn, mMode, mLong, mEight;
  int mSel;
  bit mLastRead, mLive, pend;
  logic [15:0] mNext;

  always #2 clk = ~clk;

  assign busDataIn = busRdN ? 16'h0000 : (busAddr ^ 16'hA5C3);

  ext_bus_ctl uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .reqRdata(reqRdata), .busAddr(busAddr), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .busRdN(busRdN),
    .busWrN(busWrN), .busAsN(busAsN), .ioStrbN(ioStrbN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input bit t, input bit m, input bit l, input bit e, input int s);
    @(negedge clk);
    regWe = 1'b1;
    regWdata = {1'b1, t, m, l, e, 2'(s), 1'b1};
    @(negedge clk);
    regWe = 1'b0;
    mTurn = t; mMode = m; mLong = l; mEight = e; mSel = s;
    chk(regRdata == {1'b1, t, m, l, e, 2'(s), 1'b1}, "R2 readback", int'(regRdata),
        int'({1'b1, t, m, l, e, 2'(s), 1'b1}));
  endtask

  // two request-free falling edges: FSM reaches dispatch and sits there idle
  task automatic gap();
    reqValid = 1'b0;
    @(negedge clk);
    chk(reqReady == 1'b0, "R9 ready pulse width", int'(reqReady), 0);
    @(negedge clk);
    mLastRead = 0;
    pend = 0;
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] wd);
    int lat = 0;
    int expLat;
    bit burst;
    string tag;
    int topN;
    bit expWin;
    burst = 0;
    if (wr && mLastRead && mTurn) begin
      expLat = 3; tag = "R4 turnaround";
    end else if (!wr && mMode && mLive && a == mNext) begin
      expLat = mLong ? 2 : 1; burst = 1; tag = "R5 burst cycle";
    end else begin
      expLat = 2;
      if (wr) tag = (mMode ? "R7 write basic" : "R3 basic write");
      else if (mMode && !mLive && a == mNext) tag = "R6 block boundary";
      else if (mMode) tag = "R7 non-sequential";
      else tag = "R3 basic read";
    end
    expLat += pend;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    while (1) begin
      @(negedge clk);
      lat++;
      if (reqReady || lat > 20) break;
    end
    chk(lat == expLat, tag, lat, expLat);
    chk(busAddr == a, "R3 address", int'(busAddr), int'(a));
    chk(busAsN == burst, "R5 address strobe", int'(busAsN), int'(burst));
    topN = 2 + mSel;
    expWin = ((int'(a) >> (16 - topN)) == ((1 << topN) - 1));
    chk(ioStrbN == !expWin, "R8 io strobe", int'(ioStrbN), int'(!expWin));
    if (wr) begin
      chk(busWrN == 1'b0 && busDataOe && busDataOut == wd, "R9 write data",
          int'(busDataOut), int'(wd));
      mLastRead = 0; mLive = 0;
    end else begin
      chk(busRdN == 1'b0 && reqRdata == (a ^ 16'hA5C3), "R9 read data",
          int'(reqRdata), int'(a ^ 16'hA5C3));
      mLastRead = 1;
      mNext = a + 16'd1;
      mLive = mMode && (mEight ? (mNext[2:0] != 0) : (mNext[1:0] != 0));
    end
    pend = 1;
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(regRdata == 8'hD3, "R1 reset value", int'(regRdata), 8'hD3);
    chk({busRdN, busWrN, busAsN, ioStrbN, reqReady} == 5'b11110, "R1 idle outputs",
        int'({busRdN, busWrN, busAsN, ioStrbN, reqReady}), 5'b11110);
    rstN = 1'b1;
    @(negedge clk);
    chk(regRdata == 8'hD3, "R1 after release", int'(regRdata), 8'hD3);
    mTurn = 1; mMode = 0; mLong = 1; mEight = 0; mSel = 1;
    mLastRead = 0; mLive = 0; pend = 0; mNext = '0;

    // R2: reserved bits are forced to one
    @(negedge clk); regWe = 1'b1; regWdata = 8'h00;
    @(negedge clk); regWe = 1'b0;
    chk(regRdata == 8'h81, "R2 zero write", int'(regRdata), 8'h81);
    @(negedge clk); regWe = 1'b1; regWdata = 8'hFF;
    @(negedge clk); regWe = 1'b0;
    chk(regRdata == 8'hFF, "R2 ones write", int'(regRdata), 8'hFF);

    // sweep all timing configurations
    for (int c = 0; c < 16; c++) begin
      gap();
      setCfg(c[3], c[2], c[1], c[0], 0);
      for (int k = 0; k < 10; k++) access(0, 16'h0040 + 16'(k), '0);
      access(1, 16'h1000, 16'h5A00 + 16'(c));
      access(0, 16'h0050, '0);
      access(1, 16'h1001, 16'h33CC);
      access(0, 16'h0052, '0);
      access(0, 16'h0050, '0);
      for (int k = 0; k < 5; k++) access(0, 16'h0046 + 16'(k), '0);
      gap();
      access(1, 16'h2000, 16'h0F0F);
      access(0, 16'h0060, '0);
      gap();
      access(1, 16'h2002, 16'hF0F0);
    end

    // I/O window sweep
    for (int s = 0; s < 4; s++) begin
      gap();
      setCfg(0, 0, 0, 0, s);
      access(0, 16'hC000, '0);
      access(0, 16'hBFFF, '0);
      access(1, 16'hE000, 16'h1111);
      access(0, 16'hF000, '0);
      access(1, 16'hF800, 16'h2222);
      access(0, 16'hFFFF, '0);
      access(0, 16'h0000, '0);
    end
    gap();

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule